// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is a chain of 4-bit binary up-counter stages that behaves as one wide synchronous counter. Every stage register updates on the rising clock edge, so all bits of the chain change together. Each stage can be preset from parallel data through an active-low load, and zeroed through an active-low clear. A build-time parameter selects whether clear acts at once or at the next clock edge.

Counting is gated by two enables. The first enable (P) is shared by the whole chain. The second enable (T) goes to the lowest stage. Each stage decodes a carry from its own all-ones state and its own T input, and that carry drives the T input of the stage above it. The enables therefore form a look-ahead chain with no extra gates, and P never touches the carry. The last carry leaves the block so that further chains can be attached.

Top module: `casc_counter`

## Requirements
- R1: With ASYNC_CLR=1, clearN LOW forces countOut to zero at once, without waiting for a clock edge.
- R2: With ASYNC_CLR=0, clearN LOW forces countOut to zero at the next rising clock edge, and countOut keeps its value until that edge.
- R3: Clear has priority over load: when clearN and loadN are both LOW at an edge, countOut becomes zero.
- R4: When loadN is LOW and clearN is HIGH at a rising edge, countOut takes dataIn, whatever the levels of enP and enT.
- R5: When load and clear are inactive, countOut advances by one at a rising edge only if enP and enT are both HIGH. Otherwise it holds.
- R6: Each 4-bit stage wraps from 15 to 0. The whole chain wraps from all ones to zero.
- R7: carryOut is HIGH exactly when enT is HIGH and countOut is all ones. enP has no effect on it, and it follows enT combinationally.
- R8: Inside the chain, the carry of stage k is the T enable of stage k+1. The chain therefore counts as one TOTAL_W-bit binary counter, with bits [3:0] as the lowest stage.
- R9: Load has priority over counting: a load with both enables HIGH stores dataIn, not dataIn+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all stages |
| clearN | input | 1 | Active-low clear; async or sync per ASYNC_CLR |
| loadN | input | 1 | Active-low synchronous parallel load |
| enP | input | 1 | Count enable shared by all stages; does not gate the carry |
| enT | input | 1 | Count enable of the lowest stage; also gates the carry |
| dataIn | input | STAGES*STAGE_W | Parallel preset value |
| countOut | output | STAGES*STAGE_W | Current count, stage 0 in the low bits |
| carryOut | output | 1 | Carry from the top stage, for further chaining |

## Verification
The outputs of load, clear (synchronous variant) and counting are due one register later. The bench changes inputs 1 ns after a rising edge and compares countOut 1 ns after the following edge against a model that it steps once per edge. Two results are due with no edge at all: the asynchronous clear, and the carry response to enT or to a new count. The bench checks these 1 ns after it changes the input, before any further edge. In the same window it confirms that the synchronous-clear copy has not yet changed.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  // Strobes from a stage's control decode to its datapath; at most one set per cycle.
  typedef struct packed {
    logic clearNow;  // synchronous zeroing at this edge
    logic loadNow;   // parallel preset at this edge
    logic incNow;    // advance by one at this edge
  } cntStrobe_t;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
#(
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic       clk,
  input  logic       clrN,
  input  logic       loadN,
  input  logic       enP,
  input  logic       enT,
  output cntStrobe_t strobe
);

  // Priority: clear, then load, then count.
  always_comb begin
    strobe          = '0;
    strobe.clearNow = !clrN && !ASYNC_CLR;
    strobe.loadNow  = clrN && !loadN;
    strobe.incNow   = clrN && loadN && enP && enT;
  end

  // R3, R9: the priority decode never issues two operations at once
  p_one_op_r3: assert property (@(posedge clk) $onehot0(strobe));

endmodule

// File: rtl/cnt_datapath.sv
module cnt_datapath
  import cnt_pkg::*;
#(
  parameter int STAGE_W   = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic               clk,
  input  logic               clrN,
  input  cntStrobe_t         strobe,
  input  logic [STAGE_W-1:0] dataIn,
  input  logic               tIn,
  output logic [STAGE_W-1:0] count,
  output logic               carry
);

  localparam logic [STAGE_W-1:0] ONE = STAGE_W'(1);

  logic [STAGE_W-1:0] countNext;

  always_comb begin
    if (strobe.clearNow)     countNext = '0;
    else if (strobe.loadNow) countNext = dataIn;
    else if (strobe.incNow)  countNext = count + ONE;  // natural wrap 15 -> 0
    else                     countNext = count;
  end

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clrN) begin
        if (!clrN) count <= '0;
        else       count <= countNext;
      end
      // R1: while clear is held, the register is zero at every edge
      p_async_zero_r1: assert property (@(posedge clk) !clrN |-> count == '0);
    end else begin : g_sync
      always_ff @(posedge clk) begin
        count <= countNext;
      end
      // R2: a synchronous clear strobe zeroes the register one edge later
      p_sync_zero_r2: assert property (@(posedge clk) strobe.clearNow |=> count == '0);
    end
  endgenerate

  // Carry: look-ahead decode of all-ones gated by T only
  assign carry = tIn && (&count);

  // R4: load takes the data bus
  p_load_r4: assert property (@(posedge clk) disable iff (!clrN)
    strobe.loadNow |=> count == $past(dataIn));
  // R5: increment adds exactly one (mod 2^STAGE_W, R6)
  p_inc_r5: assert property (@(posedge clk) disable iff (!clrN)
    strobe.incNow |=> count == $past(count) + ONE);
  // R5: no strobe means hold
  p_hold_r5: assert property (@(posedge clk) disable iff (!clrN)
    (strobe == '0) |=> $stable(count));

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int STAGE_W   = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic               clk,
  input  logic               clrN,
  input  logic               loadN,
  input  logic               enP,
  input  logic               enT,
  input  logic [STAGE_W-1:0] dataIn,
  output logic [STAGE_W-1:0] count,
  output logic               carry
);

  cntStrobe_t strobe;

  cnt_ctrl #(.ASYNC_CLR(ASYNC_CLR)) ctrl_i (
    .clk(clk), .clrN(clrN), .loadN(loadN), .enP(enP), .enT(enT), .strobe(strobe)
  );

  cnt_datapath #(.STAGE_W(STAGE_W), .ASYNC_CLR(ASYNC_CLR)) dp_i (
    .clk(clk), .clrN(clrN), .strobe(strobe), .dataIn(dataIn),
    .tIn(enT), .count(count), .carry(carry)
  );

endmodule

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter int STAGES    = 3,
  parameter int STAGE_W   = 4,
  parameter bit ASYNC_CLR = 1'b0,
  localparam int TOTAL_W  = STAGES * STAGE_W
) (
  input  logic               clk,
  input  logic               clearN,
  input  logic               loadN,
  input  logic               enP,
  input  logic               enT,
  input  logic [TOTAL_W-1:0] dataIn,
  output logic [TOTAL_W-1:0] countOut,
  output logic               carryOut
);

  logic [STAGES:0] tChain;

  assign tChain[0] = enT;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      cnt_stage #(.STAGE_W(STAGE_W), .ASYNC_CLR(ASYNC_CLR)) stage_i (
        .clk(clk), .clrN(clearN), .loadN(loadN), .enP(enP),
        .enT(tChain[s]),
        .dataIn(dataIn[s*STAGE_W +: STAGE_W]),
        .count(countOut[s*STAGE_W +: STAGE_W]),
        .carry(tChain[s+1])
      );
    end
  endgenerate

  assign carryOut = tChain[STAGES];

  // R6, R8: the full chain rolls over from all ones to zero
  p_chain_wrap_r6: assert property (@(posedge clk) disable iff (!clearN)
    (loadN && enP && enT && (&countOut)) |=> countOut == '0);
  // R8: the whole chain advances as one binary counter
  p_chain_inc_r8: assert property (@(posedge clk) disable iff (!clearN)
    (loadN && enP && enT) |=> countOut == $past(countOut) + TOTAL_W'(1));
  // R7: a raised top carry implies the chain is full
  p_carry_full_r7: assert property (@(posedge clk) carryOut |-> (&countOut) && enT);

endmodule

// File: tb/casc_counter_tb_top.sv
module casc_counter_tb_top;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         clearN, loadN, enP, enT;
  logic [W-1:0] dataIn;
  logic [W-1:0] syncCount, asyncCount;
  logic         syncCarry, asyncCarry;
  logic [W-1:0] refCnt;
  int           nVec = 0, nBad = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  casc_counter #(.STAGES(3), .STAGE_W(4), .ASYNC_CLR(1'b0)) dut_i (
    .clk(clk), .clearN(clearN), .loadN(loadN), .enP(enP), .enT(enT),
    .dataIn(dataIn), .countOut(syncCount), .carryOut(syncCarry));

  casc_counter #(.STAGES(3), .STAGE_W(4), .ASYNC_CLR(1'b1)) dutAsync_i (
    .clk(clk), .clearN(clearN), .loadN(loadN), .enP(enP), .enT(enT),
    .dataIn(dataIn), .countOut(asyncCount), .carryOut(asyncCarry));

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One edge; model stepped per requirements; sample 1 ns after the edge.
  task automatic tick();
    if (!clearN)     refCnt = '0;
    else if (!loadN) refCnt = dataIn;
    else if (enP && enT) refCnt = refCnt + 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    clearN = 1'b1; loadN = 1'b1; enP = 1'b0; enT = 1'b0;
  endtask

  task automatic doLoad(input logic [W-1:0] v);
    idle(); loadN = 1'b0; dataIn = v; tick(); idle();
  endtask

  task automatic t_reset();
    clearN = 1'b0; loadN = 1'b1; enP = 1'b0; enT = 1'b0; dataIn = '0;
    tick(); tick();
    check("R2 reset sync", syncCount, 12'h000);
    check("R1 reset async", asyncCount, 12'h000);
    idle();
  endtask

  task automatic t_load();
    loadN = 1'b0; enP = 1'b0; enT = 1'b0; dataIn = 12'hABC; tick();
    check("R4 load enables low", syncCount, 12'hABC);
    check("R4 load enables low async", asyncCount, 12'hABC);
    loadN = 1'b0; enP = 1'b1; enT = 1'b1; dataIn = 12'h3F7; tick();
    check("R9 load over count", syncCount, 12'h3F7);
    loadN = 1'b0; enP = 1'b1; enT = 1'b0; dataIn = 12'h51E; tick();
    check("R4 load P only", syncCount, 12'h51E);
    idle();
  endtask

  task automatic t_clear();
    doLoad(12'h5A5);
    clearN = 1'b0;  // mid-cycle, no edge yet
    #1;
    check("R1 async clear immediate", asyncCount, 12'h000);
    check("R2 sync clear waits", syncCount, 12'h5A5);
    loadN = 1'b0; dataIn = 12'h777; tick();
    check("R3 clear over load", syncCount, 12'h000);
    check("R2 sync clear at edge", syncCount, refCnt);
    idle();
  endtask

  task automatic t_count();
    doLoad(12'h00C);
    enP = 1'b1; enT = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick();
      check("R6 stage wrap count", syncCount, refCnt);
    end
    check("R8 carry into stage1", syncCount, 12'h012);
    enP = 1'b0; tick();
    check("R5 hold P low", syncCount, 12'h012);
    enP = 1'b1; enT = 1'b0; tick();
    check("R5 hold T low", syncCount, 12'h012);
    idle();
  endtask

  task automatic t_carry();
    doLoad(12'hFFF);
    enP = 1'b0; enT = 1'b1; #1;
    check("R7 carry P low", {11'd0, syncCarry}, 12'd1);
    enT = 1'b0; #1;
    check("R7 carry follows T", {11'd0, syncCarry}, 12'd0);
    enP = 1'b1; #1;
    check("R7 P no carry", {11'd0, syncCarry}, 12'd0);
    idle();
    doLoad(12'hFFE);
    enT = 1'b1; #1;
    check("R7 no carry at FFE", {11'd0, syncCarry}, 12'd0);
    idle();
  endtask

  task automatic t_rollover();
    doLoad(12'hFFE);
    enP = 1'b1; enT = 1'b1;
    tick();
    check("R8 reach full", syncCount, 12'hFFF);
    check("R7 carry at full", {11'd0, syncCarry}, 12'd1);
    tick();
    check("R6 chain wrap", syncCount, 12'h000);
    check("R6 chain wrap async", asyncCount, 12'h000);
    check("R7 carry drops", {11'd0, syncCarry}, 12'd0);
    idle();
  endtask

  task automatic t_sweep();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      clearN = (lfsr[7:3] != 5'd0);
      loadN  = (lfsr[6:2] != 5'd1);
      enP    = lfsr[0] | lfsr[8];
      enT    = lfsr[1] | lfsr[9] | lfsr[11];
      dataIn = {lfsr[15:12], lfsr[11:4]} | 12'hF00;
      tick();
      check("R8 sweep sync", syncCount, refCnt);
      check("R5 sweep async", asyncCount, refCnt);
    end
    idle();
  endtask

  initial begin
    fork
      begin
        refCnt = '0;
        t_reset();
        t_load();
        t_clear();
        t_count();
        t_carry();
        t_rollover();
        t_sweep();
      end
      begin
        #(200000 * 5);
        nVec++; nBad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule